// File: doc/BRIEF.md
# Selective Refresh Controller for a Short-Retention Cache Set

This block governs one set of a last-level cache whose storage cells hold data for only a bounded time after each write. For every way it keeps an age, counted in coarse timer ticks and restarted whenever the way's contents are written into the array. When a block comes close to losing its data, the controller decides what to do with it. The choice depends on the block's recency position and on whether its data is dirty.

Blocks in the top recency positions are treated as important and are saved. They are copied into a small holding queue and later rewritten into the array, one at a time, through a rewrite port that stays busy for a fixed number of cycles. When the queue has no room, or the block is not important, a dirty block is sent to memory as a write-back and a clean one is left to expire. A demand write to a block that is still waiting in the queue revokes the queued copy, so stale data never overwrites newer data. Tag lookup, the data path and the memory controller sit outside this block.

Top module: `svr_refresh_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every way is invalid and clean, `rw_start`, `rw_busy` and `wb_valid` are low, and way i sits at recency position i.
- R2: A demand access (`acc_valid`) with `acc_hit`=0 fills way `acc_way`, so the way becomes valid. `acc_write`=1 makes the way dirty on a fill or a hit. A read fill leaves the way clean. A read hit leaves its dirty state unchanged.
- R3: Each valid way has an age that saturates at RETAIN_AGE and rises by one on every `tick`. The age returns to 0 on a demand write, on a fill, and when a rewrite of that way starts. A way is dying once its age is at least DYING_AGE.
- R4: An access moves the accessed way to recency position 0, and every way that was ahead of it moves back one position. A way whose position is below MRU_SLOTS is important.
- R5: In a cycle with no demand access, the controller resolves the lowest-numbered valid dying way that is not expired, not queued and not already resolved. It resolves at most one way per cycle.
- R6: An important dying way is queued if the queue holds fewer than BUF_DEPTH entries at the start of the cycle. Otherwise a dirty way is written back and a clean way is dropped.
- R7: An unimportant dying way that is dirty is written back exactly once, and its dirty state is cleared. If it is clean, no request is made.
- R8: Queued ways are rewritten in the order they were queued. Each rewrite raises `rw_start` for one cycle with the way on `rw_way`, and holds `rw_busy` for REWRITE_CYCLES cycles. Two rewrite starts are at least REWRITE_CYCLES cycles apart.
- R9: No rewrite starts in the cycle after a demand write is presented.
- R10: A demand write to a queued way cancels that queue entry, and that entry never causes a rewrite.
- R11: A valid way whose age reaches RETAIN_AGE and that is not queued becomes invalid and clean.
- R12: A write-back raises `wb_valid` for one cycle with the way on `wb_way`. It is issued only for a way that was dirty, and that way is clean afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_way | input | WAY_W | Way being accessed |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_hit | input | 1 | 1 = hit on a valid way, 0 = fill |
| tick | input | 1 | Coarse timer tick that ages every valid way |
| rw_start | output | 1 | One-cycle pulse: rewrite from the queue starts |
| rw_way | output | WAY_W | Way being rewritten |
| rw_busy | output | 1 | Rewrite port occupied |
| wb_valid | output | 1 | One-cycle write-back request to memory |
| wb_way | output | WAY_W | Way to write back |
| valid_mask | output | NUM_WAYS | Per-way valid state |
| dirty_mask | output | NUM_WAYS | Per-way dirty state |

## Verification
The bench fills a set so that both important and unimportant ways include dirty and clean blocks, and it runs with a one-entry queue so that the queue is full for the neighbouring important way. This checks that a full queue sends a dirty block to memory instead of losing it. It checks that rewrites are spaced by exactly the port occupancy: a design that reused the port early would overlap two rewrites. It lets ways age past the limit and confirms that only the rewritten ways survive: a design that forgot to restart the age on a rewrite would lose them. It also writes to a way while its queued copy is pending and confirms that the copy is discarded, where a design that overlooked this would restore old data.

// File: rtl/svr_pkg.sv
// Package svr_pkg
// Shared types for the selective refresh controller.
// Assumes: nothing beyond standard SystemVerilog.
package svr_pkg;
    // Outcome chosen for the way resolved by the scan in one cycle.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_WB   = 2'd2,
        ACT_DROP = 2'd3
    } scan_act_e;
endpackage

// File: rtl/svr_age_bank.sv
// Module svr_age_bank
// One saturating age counter per way, advanced by a coarse tick.
// Flags each way as dying (at or above DYING_AGE) and as expired (at RETAIN_AGE).
// Assumes: DYING_AGE < RETAIN_AGE < 2**AGE_W; a clear wins over a tick.
module svr_age_bank #(
    parameter int NUM_WAYS   = 16,
    parameter int AGE_W      = 4,
    parameter int DYING_AGE  = 12,
    parameter int RETAIN_AGE = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_WAYS-1:0] valid,
    input  logic [NUM_WAYS-1:0] clr,
    output logic [NUM_WAYS-1:0] dying,
    output logic [NUM_WAYS-1:0] expired
);
    localparam logic [AGE_W-1:0] DYING_V  = AGE_W'(DYING_AGE);
    localparam logic [AGE_W-1:0] RETAIN_V = AGE_W'(RETAIN_AGE);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [AGE_W-1:0] age_q;

        // Count ticks on a valid way, saturating at the retention limit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                age_q <= '0;
            else if (clr[w])
                age_q <= '0;
            else if (tick && valid[w] && age_q < RETAIN_V)
                age_q <= age_q + 1'b1;
        end

        assign dying[w]   = (age_q >= DYING_V);
        assign expired[w] = (age_q >= RETAIN_V);
    end
endmodule

// File: rtl/svr_recency.sv
// Module svr_recency
// Keeps a recency position per way (0 = most recent) and flags the ways
// whose position is within the top MRU_SLOTS.
// Assumes: NUM_WAYS is a power of two; positions stay a permutation.
module svr_recency #(
    parameter int NUM_WAYS  = 16,
    parameter int MRU_SLOTS = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                touch,
    input  logic [WAY_W-1:0]    touch_way,
    output logic [NUM_WAYS-1:0] mru
);
    logic [WAY_W-1:0] rank_q [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        // Promote the touched way and push back the ways ahead of it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rank_q[w] <= WAY_W'(w);
            else if (touch) begin
                if (touch_way == WAY_W'(w))
                    rank_q[w] <= '0;
                else if (rank_q[w] < rank_q[touch_way])
                    rank_q[w] <= rank_q[w] + 1'b1;
            end
        end

        assign mru[w] = (32'(rank_q[w]) < MRU_SLOTS);
    end
endmodule

// File: rtl/svr_refresh_fifo.sv
// Module svr_refresh_fifo
// Holding queue for ways awaiting a rewrite. Each entry carries a live bit.
// A cancel clears the live bit of every entry holding that way, and a dead
// entry is later popped without causing a rewrite.
// Assumes: no push when full, no pop when empty.
module svr_refresh_fifo #(
    parameter int NUM_WAYS = 16,
    parameter int DEPTH    = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WAY_W-1:0] push_way,
    input  logic             pop,
    input  logic             cancel,
    input  logic [WAY_W-1:0] cancel_way,
    output logic             full,
    output logic             head_valid,
    output logic             head_live,
    output logic [WAY_W-1:0] head_way
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WAY_W-1:0] way_q  [DEPTH];
    logic             live_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        // Store a pushed way, or revoke the entry on a matching cancel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                way_q[e]  <= '0;
                live_q[e] <= 1'b0;
            end else if (push && wr_q == PTR_W'(e)) begin
                way_q[e]  <= push_way;
                live_q[e] <= 1'b1;
            end else if (cancel && way_q[e] == cancel_way)
                live_q[e] <= 1'b0;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign head_valid = (cnt_q != '0);
    assign head_live  = live_q[rd_q];
    assign head_way   = way_q[rd_q];
endmodule

// File: rtl/svr_refresh_ctrl.sv
// Module svr_refresh_ctrl
// Selective refresh controller for one set of a short-retention cache.
// Tracks validity, dirtiness and age per way. Resolves one dying way per idle
// cycle: important ways are queued for a rewrite, and dirty ways that cannot
// be saved are written back to memory. Expired ways are released.
// Assumes: a hit is only presented for a valid way; demand accesses take
// priority over the scan and over copy-back from the queue.
module svr_refresh_ctrl
    import svr_pkg::*;
#(
    parameter int NUM_WAYS       = 16,
    parameter int MRU_SLOTS      = 4,
    parameter int AGE_W          = 4,
    parameter int DYING_AGE      = 12,
    parameter int RETAIN_AGE     = 15,
    parameter int BUF_DEPTH      = 4,
    parameter int REWRITE_CYCLES = 6,
    localparam int WAY_W         = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [WAY_W-1:0]    acc_way,
    input  logic                acc_write,
    input  logic                acc_hit,
    input  logic                tick,
    output logic                rw_start,
    output logic [WAY_W-1:0]    rw_way,
    output logic                rw_busy,
    output logic                wb_valid,
    output logic [WAY_W-1:0]    wb_way,
    output logic [NUM_WAYS-1:0] valid_mask,
    output logic [NUM_WAYS-1:0] dirty_mask
);
    localparam int RW_W = $clog2(REWRITE_CYCLES + 1);

    logic [NUM_WAYS-1:0] valid_q, dirty_q, pend_q, done_q;
    logic [NUM_WAYS-1:0] dying, expired, mru, clr_vec, eligible, expire_vec;
    logic [RW_W-1:0]     rw_cnt_q;
    logic                acc_wr, fifo_full, head_valid, head_live;
    logic                cb_pop, rw_go, sel_found;
    logic [WAY_W-1:0]    head_way, sel_way;
    scan_act_e           act;

    assign acc_wr = acc_valid && acc_write;

    svr_age_bank #(
        .NUM_WAYS(NUM_WAYS), .AGE_W(AGE_W),
        .DYING_AGE(DYING_AGE), .RETAIN_AGE(RETAIN_AGE)
    ) u_age (
        .clk(clk), .rst_n(rst_n), .tick(tick), .valid(valid_q),
        .clr(clr_vec), .dying(dying), .expired(expired)
    );

    svr_recency #(.NUM_WAYS(NUM_WAYS), .MRU_SLOTS(MRU_SLOTS)) u_rec (
        .clk(clk), .rst_n(rst_n), .touch(acc_valid),
        .touch_way(acc_way), .mru(mru)
    );

    svr_refresh_fifo #(.NUM_WAYS(NUM_WAYS), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(act == ACT_PUSH), .push_way(sel_way),
        .pop(cb_pop), .cancel(acc_wr), .cancel_way(acc_way),
        .full(fifo_full), .head_valid(head_valid),
        .head_live(head_live), .head_way(head_way)
    );

    assign eligible   = valid_q & dying & ~expired & ~pend_q & ~done_q;
    assign expire_vec = valid_q & expired & ~pend_q;

    // Copy-back: drop dead heads freely; start a live one when the port frees up.
    assign cb_pop = head_valid && !acc_wr && (!head_live || rw_cnt_q <= RW_W'(1));
    assign rw_go  = cb_pop && head_live;

    // Ages restart on writes into the array: demand writes, fills, rewrites.
    always_comb begin
        clr_vec = '0;
        if (acc_valid && (acc_write || !acc_hit)) clr_vec[acc_way] = 1'b1;
        if (rw_go) clr_vec[head_way] = 1'b1;
    end

    // Pick the lowest-numbered eligible way and decide its outcome.
    always_comb begin
        sel_found = 1'b0;
        sel_way   = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                sel_found = 1'b1;
                sel_way   = WAY_W'(i);
            end
        end
        act = ACT_NONE;
        if (sel_found && !acc_valid) begin
            if (mru[sel_way] && !fifo_full)
                act = ACT_PUSH;
            else
                act = dirty_q[sel_way] ? ACT_WB : ACT_DROP;
        end
    end

    // Per-way state: expiry, scan outcome, copy-back, then demand access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            pend_q  <= '0;
            done_q  <= '0;
        end else begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (expire_vec[i]) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                end
                if (expire_vec[i] || clr_vec[i]) done_q[i] <= 1'b0;
            end
            case (act)
                ACT_PUSH: pend_q[sel_way] <= 1'b1;
                ACT_WB: begin
                    dirty_q[sel_way] <= 1'b0;
                    done_q[sel_way]  <= 1'b1;
                end
                ACT_DROP: done_q[sel_way] <= 1'b1;
                default: ;
            endcase
            if (rw_go) pend_q[head_way] <= 1'b0;
            if (acc_valid) begin
                valid_q[acc_way] <= 1'b1;
                if (acc_write) begin
                    dirty_q[acc_way] <= 1'b1;
                    pend_q[acc_way]  <= 1'b0;
                end else if (!acc_hit)
                    dirty_q[acc_way] <= 1'b0;
            end
        end
    end

    // Rewrite port occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rw_cnt_q <= '0;
        else if (rw_go)
            rw_cnt_q <= RW_W'(REWRITE_CYCLES);
        else if (rw_cnt_q != '0)
            rw_cnt_q <= rw_cnt_q - 1'b1;
    end

    // Registered request pulses towards the array and memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_start <= 1'b0;
            rw_way   <= '0;
            wb_valid <= 1'b0;
            wb_way   <= '0;
        end else begin
            rw_start <= rw_go;
            if (rw_go) rw_way <= head_way;
            wb_valid <= (act == ACT_WB);
            if (act == ACT_WB) wb_way <= sel_way;
        end
    end

    assign rw_busy    = (rw_cnt_q != '0);
    assign valid_mask = valid_q;
    assign dirty_mask = dirty_q;
endmodule

// File: rtl/svr_refresh_ctrl_chk.sv
// Module svr_refresh_ctrl_chk
// Temporal checks on the controller's ports, bound into every instance.
// Assumes: synchronous active-low reset asserted from time zero.
module svr_refresh_ctrl_chk #(
    parameter int NUM_WAYS       = 16,
    parameter int REWRITE_CYCLES = 6,
    localparam int WAY_W         = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic                acc_write,
    input logic                rw_start,
    input logic [WAY_W-1:0]    rw_way,
    input logic                rw_busy,
    input logic                wb_valid,
    input logic [WAY_W-1:0]    wb_way,
    input logic [NUM_WAYS-1:0] valid_mask,
    input logic [NUM_WAYS-1:0] dirty_mask
);
    int                  gap_q;
    logic [NUM_WAYS-1:0] dirty_d;

    // Cycles since the last rewrite start, saturating at the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= REWRITE_CYCLES;
        else if (rw_start)
            gap_q <= 1;
        else if (gap_q < REWRITE_CYCLES)
            gap_q <= gap_q + 1;
    end

    // Dirty state one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty_d <= '0;
        else        dirty_d <= dirty_mask;
    end

    a_r8_rw_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rw_start |-> gap_q >= REWRITE_CYCLES);
    a_r8_rw_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rw_start |-> rw_busy);
    a_r8_rw_valid_way: assert property (@(posedge clk) disable iff (!rst_n)
        rw_start |-> valid_mask[rw_way]);
    a_r9_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        rw_start |-> !$past(acc_valid && acc_write));
    a_r12_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (dirty_d[wb_way] && !dirty_mask[wb_way]));
    a_r2_dirty_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_mask & ~valid_mask) == '0);
endmodule

bind svr_refresh_ctrl svr_refresh_ctrl_chk #(
    .NUM_WAYS(NUM_WAYS), .REWRITE_CYCLES(REWRITE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .rw_start(rw_start), .rw_way(rw_way), .rw_busy(rw_busy),
    .wb_valid(wb_valid), .wb_way(wb_way),
    .valid_mask(valid_mask), .dirty_mask(dirty_mask)
);

// File: tb/svr_refresh_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for svr_refresh_ctrl with a one-entry queue, so the queue-full
// outcome is reached by neighbouring important ways.
module svr_refresh_ctrl_tb;
    localparam int NW = 16;
    localparam int WW = 4;
    localparam int RWC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0, acc_hit = 1'b0, tick = 1'b0;
    logic [WW-1:0] acc_way = '0;
    logic          rw_start, rw_busy, wb_valid;
    logic [WW-1:0] rw_way, wb_way;
    logic [NW-1:0] valid_mask, dirty_mask;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 1'b0;
    int rw_log [32], rw_cyc [32], wb_log [32];
    int rw_n = 0, wb_n = 0;

    always #4 clk = ~clk;

    svr_refresh_ctrl #(.BUF_DEPTH(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_way(acc_way),
        .acc_write(acc_write), .acc_hit(acc_hit), .tick(tick),
        .rw_start(rw_start), .rw_way(rw_way), .rw_busy(rw_busy),
        .wb_valid(wb_valid), .wb_way(wb_way),
        .valid_mask(valid_mask), .dirty_mask(dirty_mask)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Log request pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rw_start && rw_n < 32) begin
            rw_log[rw_n] = int'(rw_way);
            rw_cyc[rw_n] = cyc;
            rw_n++;
        end
        if (rst_n && wb_valid && wb_n < 32) begin
            wb_log[wb_n] = int'(wb_way);
            wb_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic access(input int way, input bit wr, input bit hit);
        @(negedge clk);
        acc_valid = 1'b1; acc_way = WW'(way); acc_write = wr; acc_hit = hit;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid_mask", int'(valid_mask), 0);
        chk("R1 dirty_mask", int'(dirty_mask), 0);
        chk("R1 rw_busy", int'(rw_busy), 0);
        chk("R1 pulses", int'(rw_start) + int'(wb_valid), 0);

        // R2/R4: fill 15 down to 0; ways 1, 3, 9 by write. Then read hit on 8.
        for (int w = NW - 1; w >= 0; w--)
            access(w, (w == 1 || w == 3 || w == 9), 1'b0);
        access(8, 1'b0, 1'b1);
        chk("R2 valid after fills", int'(valid_mask), 'hFFFF);
        chk("R2 dirty after fills", int'(dirty_mask), 'h020A);

        // R5/R6/R7/R8: age everything to the dying threshold.
        ticks(12);
        repeat (40) @(negedge clk);
        chk("R8 rewrite count", rw_n, 3);
        chk("R6 rewrite order first", rw_log[0], 0);
        chk("R6 rewrite order second", rw_log[1], 2);
        chk("R4 promoted way rewritten", rw_log[2], 8);
        chk("R8 spacing 1", rw_cyc[1] - rw_cyc[0], RWC);
        chk("R8 spacing 2", rw_cyc[2] - rw_cyc[1], RWC);
        chk("R12 write-back count", wb_n, 3);
        chk("R6 full queue dirty write-back", wb_log[0], 1);
        chk("R7 unimportant dirty first", wb_log[1], 3);
        chk("R7 unimportant dirty second", wb_log[2], 9);
        chk("R12 dirty cleared", int'(dirty_mask), 0);
        chk("R5 all still valid", int'(valid_mask), 'hFFFF);

        // R3/R11: three more ticks expire all but the rewritten ways.
        ticks(3);
        repeat (4) @(negedge clk);
        chk("R11 survivors", int'(valid_mask), 'h0105);
        chk("R7 no repeat write-back", wb_n, 3);

        // R10/R9: age the survivors again, then write way 0 while it is queued.
        ticks(9);
        @(negedge clk);
        acc_valid = 1'b1; acc_way = WW'(0); acc_write = 1'b1; acc_hit = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 one rewrite after cancel", rw_n, 4);
        chk("R10 only way 8 rewritten", rw_log[3], 8);
        chk("R6 full queue clean drop", wb_n, 3);
        chk("R3 demand write dirty", int'(dirty_mask), 'h0001);

        ticks(3);
        repeat (4) @(negedge clk);
        chk("R3 R11 survivors after cancel", int'(valid_mask), 'h0101);
        chk("R10 cancelled way not restored", rw_n, 4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule